// File: doc/BRIEF.md
# Four-Bit Adder-Subtracter with Hex Display Harness

This block adds or subtracts two 4-bit two's-complement numbers and presents the outcome on two 7-segment digits. It is meant to sit behind a row of nine slide switches. It drives nine indicator LEDs that echo those switches. The arithmetic is a ripple of four full-adder cells, running from the least significant bit to the most significant bit. In subtract mode each B bit passes through an XOR with the mode bit, and the carry into the lowest cell is 1, so the core forms A + ~B + 1.

The low digit shows the 4-bit result in hexadecimal. The high digit shows a flag nibble, with the carry-out in bit 3, the signed-overflow flag in bit 2 and zeros below. That digit can only ever read 0, 4, 8 or C. The whole block is combinational: it has no clock, no reset and no state.

Top module: `addsub4_display`

## Requirements
- R1: The switch word is split as follows: sw[8] is the mode (0 add, 1 subtract), sw[7:4] is operand A and sw[3:0] is operand B. In add mode the result is (A + B) mod 16, and the carry-out is 1 exactly when A + B > 15 (unsigned).
- R2: In subtract mode the result is (A - B) mod 16. The carry-out is the raw carry of A + ~B + 1, so it is 1 exactly when A >= B (unsigned), meaning no borrow.
- R3: The overflow flag is 1 exactly when the true signed result falls outside -8..7, with A and B read as two's complement. This holds in both modes.
- R4: led[i] equals sw[i] for every i in 0..8, whatever the mode and operands.
- R5: seg_lo shows the 4-bit result. Both digit outputs are active-low (a lit segment is 0), with segment a on bit 0 through segment g on bit 6.
- R6: The digit patterns, given active-high as hex on bits g..a, are: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D, 7=07, 8=7F, 9=6F, A=77, b=7C, C=39, d=5E, E=79, F=71. The letters b and d use their lowercase forms.
- R7: seg_hi shows the nibble {carry-out, overflow, 0, 0}. It therefore only ever shows 0, 4, 8 or C.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sw | input | 9 | Switch word: mode, operand A, operand B |
| led | output | 9 | Indicator LEDs mirroring the switches |
| seg_lo | output | 7 | Active-low segments of the result digit |
| seg_hi | output | 7 | Active-low segments of the carry/overflow digit |

## Verification
The block has a single fixed configuration: a 4-bit datapath with a 9-bit switch word. The bench builds it that way and sweeps all 512 switch patterns. Every add and subtract pair is therefore applied, including the signed corners (7 + 1, -8 - 1, -8 + -8, 0 - (-8)) and every borrow case. Each of the sixteen result glyphs and all four flag glyphs appear on the digits. The expected values come from integer arithmetic on the operands, not from any carry chain.

// File: rtl/addsub4_display.sv
module addsub4_display (
  input  logic [8:0] sw,
  output logic [8:0] led,
  output logic [6:0] seg_lo,
  output logic [6:0] seg_hi
);
  localparam int W = 4;

  logic         sub;
  logic [W-1:0] a, b, bx, sum;
  logic [W:0]   c;
  logic         cout, ovf;

  assign sub  = sw[2*W];
  assign a    = sw[2*W-1:W];
  assign b    = sw[W-1:0];
  assign bx   = b ^ {W{sub}};
  assign c[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum[i]  = a[i] ^ bx[i] ^ c[i];
    assign c[i+1]  = (a[i] & bx[i]) | (c[i] & (a[i] ^ bx[i]));
  end

  assign cout = c[W];
  assign ovf  = c[W] ^ c[W-1];
  assign led  = sw;

  function automatic logic [6:0] hex7(input logic [3:0] v);
    logic [6:0] lit;
    case (v)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
    return ~lit;
  endfunction

  assign seg_lo = hex7(sum);
  assign seg_hi = hex7({cout, ovf, 2'b00});
endmodule

// File: rtl/addsub4_display_chk.sv
module addsub4_display_chk (
  input logic       sub,
  input logic [3:0] a,
  input logic [3:0] b,
  input logic [3:0] sum,
  input logic       cout,
  input logic       ovf,
  input logic [6:0] seg_hi
);
  logic [3:0] bm;
  assign bm = sub ? ~b : b;

  always_comb begin
    if (!sub) begin
      AST_ADD_RESULT: assert ({cout, sum} == 5'(a) + 5'(b)) else $error("add result mismatch"); // R1
    end
    if (sub) begin
      AST_SUB_RESULT: assert ({cout, sum} == 5'(a) + 5'(bm) + 5'd1) else $error("sub result mismatch"); // R2
    end
    AST_SIGNED_OVERFLOW: assert (ovf == ((a[3] == bm[3]) && (sum[3] != a[3]))) else $error("overflow mismatch"); // R3
    AST_FLAG_DIGIT: assert (seg_hi == 7'h40 || seg_hi == 7'h19 || seg_hi == 7'h00 || seg_hi == 7'h46) else $error("flag digit glyph"); // R7
  end
endmodule

bind addsub4_display addsub4_display_chk u_chk (
  .sub(sub), .a(a), .b(b), .sum(sum), .cout(cout), .ovf(ovf), .seg_hi(seg_hi)
);

// File: tb/tb_addsub4_display.sv
module tb_addsub4_display;
  logic       clk = 0;
  logic [8:0] sw  = '0;
  logic [8:0] led;
  logic [6:0] seg_lo, seg_hi;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  addsub4_display dut (.sw(sw), .led(led), .seg_lo(seg_lo), .seg_hi(seg_hi));

  // R6 glyph table, active-low, bit0 = a .. bit6 = g (R5)
  function automatic logic [6:0] glyph(input int v);
    logic [6:0] on;
    case (v)
      0: on = 7'h3F;  1: on = 7'h06;  2: on = 7'h5B;  3: on = 7'h4F;
      4: on = 7'h66;  5: on = 7'h6D;  6: on = 7'h7D;  7: on = 7'h07;
      8: on = 7'h7F;  9: on = 7'h6F; 10: on = 7'h77; 11: on = 7'h7C;
      12: on = 7'h39; 13: on = 7'h5E; 14: on = 7'h79; default: on = 7'h71;
    endcase
    return ~on;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s sw=%03h actual=%0h expected=%0h", req, sw, act, exp);
    end
  endtask

  initial begin
    // idle state: all switches low shows 0 on both digits
    @(negedge clk);
    check("R5 idle result digit", seg_lo, glyph(0));
    check("R7 idle flag digit", seg_hi, glyph(0));
    check("R4 idle leds", led, 0);
    for (int v = 0; v < 512; v++) begin
      int av, bv, sa, sb, r, s_exp, c_exp, o_exp;
      bit m;
      @(posedge clk);
      sw <= 9'(v);
      @(negedge clk);
      m  = v[8];
      av = (v >> 4) & 15;
      bv = v & 15;
      sa = (av > 7) ? av - 16 : av;
      sb = (bv > 7) ? bv - 16 : bv;
      if (m) begin
        s_exp = (av - bv) & 15;
        c_exp = (av >= bv) ? 1 : 0;
        r     = sa - sb;
      end else begin
        s_exp = (av + bv) & 15;
        c_exp = (av + bv > 15) ? 1 : 0;
        r     = sa + sb;
      end
      o_exp = (r > 7 || r < -8) ? 1 : 0;
      check("R4 led mirror", led, v);
      if (m) check("R2 R5 R6 difference digit", seg_lo, glyph(s_exp));
      else   check("R1 R5 R6 sum digit", seg_lo, glyph(s_exp));
      check(m ? "R2 R3 R7 flag digit" : "R1 R3 R7 flag digit", seg_hi, glyph(c_exp * 8 + o_exp * 4));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule